// File: doc/BRIEF.md
# Handshaked Single-Master Peripheral Interconnect

This block joins one bus master to twelve memory-mapped slaves over a four-phase request/acknowledge protocol. Writes and reads use separate one-way 16-bit data paths, so no tristate nets are needed. The master presents an address, write data and a write flag, then raises its request. The fabric registers these values and forwards them to every slave. It decodes the upper address byte into one select line, and from there into one request line, for the slave that owns that page.

A slave answers when it is ready. For a read, it first places its data on its own read lane, then raises its acknowledge. It may delay the acknowledge for any number of cycles, and this stalls the master. The fabric registers the acknowledge and the chosen read lane, then passes them back to the master.

The master then lowers its request, and the slave lowers its acknowledge in turn. An access to a page that no slave owns is acknowledged by the fabric itself with zero data, so the master never hangs. No master signal reaches a slave, and no slave signal reaches the master, without passing through a register in the fabric.

Top module: `hsb_fabric`

## Requirements
- R1: While reset is high, and just after it is released, m_ack, m_rdata, s_sel, s_req, s_we, s_addr and s_wdata are all zero.
- R2: At the clock edge that accepts a request, s_addr, s_wdata and s_we take the values of m_addr, m_wdata and m_we. These values go to all slaves and stay unchanged until the transfer ends.
- R3: The page is m_addr[15:8]. A page below 12 drives s_sel bit `page` as a one-hot select. Any other page leaves s_sel all zero. s_sel holds from acceptance until the transfer ends.
- R4: s_req is zero in the cycle in which m_req first rises. One clock edge later, only the selected slave's s_req bit is high.
- R5: If a slave raises s_ack L cycles after it sees s_req, m_ack rises exactly 3+L clock edges after m_req was raised. The stall may be any length.
- R6: m_ack stays high until m_req falls. Then s_req falls at the next edge. On a hit, m_ack falls one edge after the slave drops s_ack, which is three edges after m_req fell. On a miss it falls two edges after m_req fell.
- R7: On a read, m_rdata equals the selected slave's lane s_rdata[16*i+15:16*i] as sampled with its acknowledge. It stays stable while m_ack is high.
- R8: On a miss, m_ack rises two edges after m_req rises, m_rdata is zero, and no slave is selected or written.
- R9: The slave index is captured when the request is accepted. Changes to m_addr or m_wdata during the transfer have no effect on selection, forwarded values or read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 1 | Master request |
| m_we | input | 1 | Master write flag (1 = write) |
| m_addr | input | 16 | Master address |
| m_wdata | input | 16 | Master write data |
| m_ack | output | 1 | Acknowledge to master |
| m_rdata | output | 16 | Read data to master |
| s_sel | output | 12 | One-hot slave select |
| s_req | output | 12 | Per-slave request |
| s_we | output | 1 | Shared write flag to slaves |
| s_addr | output | 16 | Shared address to slaves |
| s_wdata | output | 16 | Shared write data to slaves |
| s_ack | input | 12 | Per-slave acknowledge |
| s_rdata | input | 192 | Packed slave read lanes, lane i at bits 16*i+15:16*i |

## Verification
The main sweep writes and then reads four words in every page from 0 through 15, plus page 255. This tells decoded pages apart from unmapped pages, and checks that a miss write leaves every slave unchanged.

Slave latencies of zero to three cycles, and one long stall, test that the acknowledge latency tracks the slave's delay exactly and is not fixed. A transfer that changes the address and write data after acceptance tells a captured index apart from a live decode. The release timing is timed separately for hits and misses.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2,
    ST_REL  = 2'd3
  } hsb_state_e;
endpackage

// File: rtl/hsb_decode.sv
module hsb_decode #(
  parameter int AW = 16,
  parameter int N  = 12,
  parameter int PW = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  sel_oh,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [PW-1:0] page;
  assign page = addr[AW-1 -: PW];

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign sel_oh[g] = (page == PW'(g));
  end

  assign hit = |sel_oh;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_oh[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/hsb_rsp_mux.sv
module hsb_rsp_mux #(
  parameter int N  = 12,
  parameter int DW = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*DW-1:0] lanes,
  input  logic [N-1:0]    acks,
  input  logic [IW-1:0]   idx,
  output logic [DW-1:0]   rdata,
  output logic            ack
);
  always_comb begin
    rdata = '0;
    ack   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (idx == IW'(i)) begin
        rdata = lanes[i*DW +: DW];
        ack   = acks[i];
      end
    end
  end
endmodule

// File: rtl/hsb_ctrl.sv
module hsb_ctrl
  import hsb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int N  = 12,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          m_req,
  input  logic          m_we,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  input  logic [N-1:0]  dec_sel,
  input  logic          dec_hit,
  input  logic [IW-1:0] dec_idx,
  input  logic          lane_ack,
  input  logic [DW-1:0] lane_rdata,
  output logic [IW-1:0] idx_q,
  output logic          m_ack,
  output logic [DW-1:0] m_rdata,
  output logic [N-1:0]  s_sel,
  output logic [N-1:0]  s_req,
  output logic          s_we,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_wdata
);
  hsb_state_e state;
  logic       hit_q;
  logic       reqph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idx_q   <= '0;
      hit_q   <= 1'b0;
      reqph_q <= 1'b0;
      s_sel   <= '0;
      s_we    <= 1'b0;
      s_addr  <= '0;
      s_wdata <= '0;
      m_ack   <= 1'b0;
      m_rdata <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (m_req && !m_ack) begin
            idx_q   <= dec_idx;
            hit_q   <= dec_hit;
            s_sel   <= dec_sel;
            reqph_q <= dec_hit;
            s_addr  <= m_addr;
            s_wdata <= m_wdata;
            s_we    <= m_we;
            state   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (!hit_q) begin
            m_ack   <= 1'b1;
            m_rdata <= '0;
            state   <= ST_HOLD;
          end else if (lane_ack) begin
            m_ack   <= 1'b1;
            m_rdata <= lane_rdata;
            state   <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (!m_req) begin
            reqph_q <= 1'b0;
            state   <= ST_REL;
          end
        end
        default: begin
          if (!hit_q || !lane_ack) begin
            m_ack <= 1'b0;
            s_sel <= '0;
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign s_req = s_sel & {N{reqph_q}};

  a_r3_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_sel));

  a_r4_req_registered: assert property (@(posedge clk) disable iff (rst)
    $rose(|s_req) |-> $past(m_req));

  a_r5_ack_follows_slave: assert property (@(posedge clk) disable iff (rst)
    ($rose(m_ack) && hit_q) |-> $past(lane_ack));

  a_r6_ack_held: assert property (@(posedge clk) disable iff (rst)
    (m_ack && m_req) |=> m_ack);

  a_r7_rdata_stable: assert property (@(posedge clk) disable iff (rst)
    (m_ack && $past(m_ack)) |-> $stable(m_rdata));

  a_r8_miss_zero: assert property (@(posedge clk) disable iff (rst)
    ($rose(m_ack) && !hit_q) |-> (m_rdata == '0 && s_sel == '0));

  a_r9_idx_stable: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(idx_q));
endmodule

// File: rtl/hsb_fabric.sv
module hsb_fabric #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int N  = 12,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          m_req,
  input  logic          m_we,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  output logic          m_ack,
  output logic [DW-1:0] m_rdata,
  output logic [N-1:0]  s_sel,
  output logic [N-1:0]  s_req,
  output logic          s_we,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_wdata,
  input  logic [N-1:0]  s_ack,
  input  logic [N*DW-1:0] s_rdata
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  dec_sel;
  logic          dec_hit;
  logic [IW-1:0] dec_idx;
  logic [IW-1:0] idx_q;
  logic          lane_ack;
  logic [DW-1:0] lane_rdata;

  hsb_decode #(.AW(AW), .N(N), .PW(PW), .IW(IW)) u_dec (
    .addr   (m_addr),
    .sel_oh (dec_sel),
    .hit    (dec_hit),
    .idx    (dec_idx)
  );

  hsb_rsp_mux #(.N(N), .DW(DW), .IW(IW)) u_mux (
    .lanes (s_rdata),
    .acks  (s_ack),
    .idx   (idx_q),
    .rdata (lane_rdata),
    .ack   (lane_ack)
  );

  hsb_ctrl #(.AW(AW), .DW(DW), .N(N), .IW(IW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .m_req      (m_req),
    .m_we       (m_we),
    .m_addr     (m_addr),
    .m_wdata    (m_wdata),
    .dec_sel    (dec_sel),
    .dec_hit    (dec_hit),
    .dec_idx    (dec_idx),
    .lane_ack   (lane_ack),
    .lane_rdata (lane_rdata),
    .idx_q      (idx_q),
    .m_ack      (m_ack),
    .m_rdata    (m_rdata),
    .s_sel      (s_sel),
    .s_req      (s_req),
    .s_we       (s_we),
    .s_addr     (s_addr),
    .s_wdata    (s_wdata)
  );
endmodule

// File: tb/tb_hsb_fabric.sv
module tb_hsb_fabric;
  localparam int N  = 12;
  localparam int DW = 16;
  localparam int AW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic          m_req, m_we;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata;
  logic          m_ack;
  logic [DW-1:0] m_rdata;
  logic [N-1:0]  s_sel, s_req;
  logic          s_we;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_wdata;
  wire  [N-1:0]  s_ack;
  wire  [N*DW-1:0] s_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int lat [N];
  logic [15:0] shadow [N][4];

  hsb_fabric dut (
    .clk(clk), .rst(rst), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata), .s_sel(s_sel),
    .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_ack(s_ack), .s_rdata(s_rdata)
  );

  for (genvar i = 0; i < N; i++) begin : g_slv
    logic        ack_l;
    logic [15:0] rd_l;
    logic [15:0] mem [4];
    int          cnt;
    always_ff @(posedge clk) begin
      if (rst) begin
        ack_l <= 1'b0;
        rd_l  <= 16'hDE00 | 16'(i);
        cnt   <= 0;
      end else if (s_req[i] && s_sel[i] && !ack_l) begin
        if (cnt >= lat[i]) begin
          ack_l <= 1'b1;
          cnt   <= 0;
          if (s_we) mem[s_addr[1:0]] <= s_wdata;
          else      rd_l <= mem[s_addr[1:0]];
        end else begin
          cnt <= cnt + 1;
        end
      end else if (!s_req[i] && ack_l) begin
        ack_l <= 1'b0;
      end
    end
    assign s_ack[i] = ack_l;
    assign s_rdata[i*DW +: DW] = rd_l;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [15:0] g_rd;

  task automatic xfer(input logic we, input logic [15:0] addr, input logic [15:0] wd,
                      input bit swap);
    logic [7:0]   page;
    bit           hit;
    logic [N-1:0] oh;
    int           n, nd, exp_n;
    bit           stable;
    page = addr[15:8];
    hit  = (page < 8'(N));
    oh   = hit ? (N'(1) << page) : '0;
    @(negedge clk);
    m_addr = addr; m_wdata = wd; m_we = we; m_req = 1'b1;
    #1;
    chk("R4 no slave request in same cycle", 32'(s_req), 32'h0);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        chk("R4 request one edge later", 32'(s_req), 32'(hit ? oh : '0));
        if (swap) begin
          m_addr  = addr ^ 16'h0300;
          m_wdata = ~wd;
          m_we    = ~we;
        end
      end
    end while (!m_ack && n < 400);
    exp_n = hit ? 3 + lat[page] : 2;
    chk(hit ? "R5 ack latency" : "R8 miss ack latency", 32'(n), 32'(exp_n));
    chk(hit ? "R3 select" : "R8 no select", 32'(s_sel), 32'(oh));
    chk("R2 s_addr / R9", 32'(s_addr), 32'(addr));
    chk("R2 s_wdata / R9", 32'(s_wdata), 32'(wd));
    chk("R2 s_we / R9", 32'(s_we), 32'(we));
    g_rd = m_rdata;
    @(negedge clk);
    chk("R6 ack held while request high", 32'(m_ack), 32'h1);
    m_req = 1'b0;
    nd = 0;
    stable = 1'b1;
    do begin
      @(negedge clk);
      nd++;
      if (nd == 1) chk("R6 slave request dropped", 32'(s_req), 32'h0);
      if (m_ack && m_rdata !== g_rd) stable = 1'b0;
    end while (m_ack && nd < 400);
    chk("R6 release timing", 32'(nd), 32'(hit ? 3 : 2));
    chk("R7 read data stable", 32'(stable), 32'h1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) lat[i] = i % 4;
    rst = 1'b1; m_req = 1'b0; m_we = 1'b0; m_addr = '0; m_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset m_ack", 32'(m_ack), 32'h0);
    chk("R1 reset m_rdata", 32'(m_rdata), 32'h0);
    chk("R1 reset s_sel", 32'(s_sel), 32'h0);
    chk("R1 reset s_req", 32'(s_req), 32'h0);
    chk("R1 reset s_addr", 32'(s_addr), 32'h0);
    chk("R1 reset s_wdata", 32'(s_wdata), 32'h0);
    chk("R1 reset s_we", 32'(s_we), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release m_ack", 32'(m_ack), 32'h0);

    // write sweep: pages 0..15 and 255, four words each
    for (int p = 0; p < 17; p++) begin
      for (int w = 0; w < 4; w++) begin
        logic [7:0]  pg;
        logic [15:0] d;
        pg = (p == 16) ? 8'hFF : 8'(p);
        d  = 16'(p * 37 + w * 11 + 16'h1234);
        xfer(1'b1, {pg, 8'(w)}, d, 1'b0);
        if (pg < 8'(N)) shadow[pg][w] = d;
      end
    end
    // read sweep: hits return written data, misses return zero
    for (int p = 0; p < 17; p++) begin
      for (int w = 0; w < 4; w++) begin
        logic [7:0] pg;
        pg = (p == 16) ? 8'hFF : 8'(p);
        xfer(1'b0, {pg, 8'(w)}, 16'h0, 1'b0);
        if (pg < 8'(N)) chk("R7 read data", 32'(g_rd), 32'(shadow[pg][w]));
        else            chk("R8 miss read zero", 32'(g_rd), 32'h0);
      end
    end
    // long stall
    lat[5] = 25;
    xfer(1'b0, 16'h0502, 16'h0, 1'b0);
    chk("R5 stalled read data", 32'(g_rd), 32'(shadow[5][2]));
    lat[5] = 1;
    // inputs changed mid-transfer
    xfer(1'b1, 16'h0301, 16'hA5C3, 1'b1);
    shadow[3][1] = 16'hA5C3;
    xfer(1'b0, 16'h0301, 16'h0, 1'b0);
    chk("R9 captured target written", 32'(g_rd), 32'h0000A5C3);
    xfer(1'b0, 16'h0001, 16'h0, 1'b0);
    chk("R9 other page untouched", 32'(g_rd), 32'(shadow[0][1]));
    xfer(1'b0, 16'h0B03, 16'h0, 1'b1);
    chk("R9 read with swapped address", 32'(g_rd), 32'(shadow[11][3]));
    finish_run();
  end
endmodule